// File: doc/BRIEF.md
# Thread Context Save/Restore Engine

The engine moves one thread's register context between a core's register file and a context store. A context holds seventeen 32-bit words: the sixteen general registers and one program counter/status word. On a save command it reads the registers and writes them to the store. On a restore command it reads the store and writes the registers back. The context store may be on-chip SRAM or off-chip memory. Because the engine runs on its own, a scheduler can prefetch the next thread and save the outgoing one while the cores keep working. When the core finally switches threads, it only sees a short delay.

The memory port width is set at elaboration. Each beat carries as many consecutive context words as fit, so a wider bus needs fewer cycles. The register file side has one lane per word of the beat. Each lane has a register select, a valid flag, read data and a write enable. The memory side is a request/ready handshake. A beat completes in any cycle where ready is high. For reads, the store presents the data in that same cycle.

Top module: `ctx_switch_engine`

## Requirements
- R1: While reset is asserted and right after it, busy, done, cmd_reject, mem_req and every rf_we bit are 0.
- R2: A command with cmd_valid high while busy is low is accepted. busy is high from the next cycle. mem_we is 1 for a save (cmd_restore=0) and 0 for a restore (cmd_restore=1).
- R3: A command with cmd_valid high while busy is high raises cmd_reject in that same cycle. It does not change the thread, the direction or the beat sequence of the transfer in progress.
- R4: Transfer word k carries register R(15-k) for k = 0..15, and word 16 carries the program counter/status word. The register select code is 15-k for the general registers and 16 for the status word. Lane i of beat b carries word b*WPB+i, in bus bits [32i+31:32i], where WPB = BUS_W/32. A lane with no word has select code 31 and its valid flag low.
- R5: A transfer takes BEATS = ceil(17/WPB) beats. That is 17 beats on a 32-bit bus and 9 on a 64-bit bus. Each beat takes one cycle while mem_ready is high.
- R6: During a transfer, mem_addr equals tid*BEATS plus the current beat index.
- R7: While mem_ready is low, the beat does not advance: mem_addr and the selects hold, and no rf_we bit is set.
- R8: On a save, each valid lane of mem_wdata equals that lane's rf_rdata. Unused lanes are driven as zero.
- R9: On a restore, rf_we is set for each valid lane in every cycle where mem_ready is high, and rf_wdata equals mem_rdata.
- R10: done pulses for one cycle, in the cycle after the final beat completes. busy is low in that cycle, so a command presented then is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_restore | input | 1 | 1 = restore into registers, 0 = save to store |
| cmd_tid | input | TID_W | Thread number |
| cmd_reject | output | 1 | Command refused because the engine is busy |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_sel | output | WPB*5 | Per-lane register select code |
| rf_lane_vld | output | WPB | Per-lane word present |
| rf_rdata | input | BUS_W | Register read data, per lane |
| rf_we | output | WPB | Per-lane register write enable |
| rf_wdata | output | BUS_W | Register write data, per lane |
| mem_req | output | 1 | Store access request |
| mem_we | output | 1 | Store write (save) when 1 |
| mem_addr | output | AW | Store beat address |
| mem_wdata | output | BUS_W | Store write data |
| mem_rdata | input | BUS_W | Store read data, valid with mem_ready |
| mem_ready | input | 1 | Beat accepted this cycle |

## Verification
Two things can fall in the same cycle: the completion of one transfer and the arrival of the next command. A related case is a command that arrives in the last beat. The bench chains every operation so that the next command is presented in the done cycle, and expects it to be accepted. It also places a rejected command in the middle of a transfer, partly during stalled beats. After that it checks that the addresses and selects keep following the original thread's sequence. The sweep covers every thread in both directions, with a 64-bit bus so that the final beat is half filled, and with and without ready stalls.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int CTX_WORDS = 17;
  localparam int GPR_COUNT = 16;
  localparam int WORD_W    = 32;
  localparam int SEL_W     = 5;
  localparam logic [SEL_W-1:0] SEL_STATUS = 5'd16;
  localparam logic [SEL_W-1:0] SEL_NONE   = 5'd31;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;

  function automatic int beats_for(input int bus_w);
    int wpb;
    wpb = bus_w / WORD_W;
    return (CTX_WORDS + wpb - 1) / wpb;
  endfunction
endpackage

// File: rtl/ctx_beat_seq.sv
module ctx_beat_seq
  import ctx_pkg::*;
#(
  parameter int BEATS = 17,
  parameter int TID_W = 3,
  localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_restore,
  input  logic [TID_W-1:0] cmd_tid,
  input  logic             mem_ready,
  output logic             cmd_reject,
  output logic             busy,
  output logic             done,
  output logic             op_restore,
  output logic [TID_W-1:0] tid,
  output logic [BW-1:0]    beat
);
  seq_state_e       state_q, state_d;
  logic             op_q, op_d;
  logic [TID_W-1:0] tid_q, tid_d;
  logic [BW-1:0]    beat_q, beat_d;
  logic             done_q, done_d;
  logic             accept, step, last;

  always_comb begin
    accept  = cmd_valid && (state_q == ST_IDLE);
    step    = (state_q == ST_RUN) && mem_ready;
    last    = (beat_q == BW'(BEATS - 1));
    state_d = state_q;
    op_d    = op_q;
    tid_d   = tid_q;
    beat_d  = beat_q;
    done_d  = step && last;
    if (accept) begin
      state_d = ST_RUN;
      op_d    = cmd_restore;
      tid_d   = cmd_tid;
      beat_d  = '0;
    end else if (step) begin
      if (last) begin
        state_d = ST_IDLE;
        beat_d  = '0;
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= 1'b0;
      tid_q   <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept || step) begin
        op_q   <= op_d;
        tid_q  <= tid_d;
        beat_q <= beat_d;
      end
    end
  end

  assign cmd_reject = cmd_valid && (state_q == ST_RUN);
  assign busy       = (state_q == ST_RUN);
  assign done       = done_q;
  assign op_restore = op_q;
  assign tid        = tid_q;
  assign beat       = beat_q;

  // R3: a transfer in progress keeps its thread and direction
  p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> ($stable(tid_q) && $stable(op_q)));
  // R7: no advance without ready
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !mem_ready) |=> ($stable(beat_q) && state_q == ST_RUN));
  // R5: beat index stays inside the context
  p_beat_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_q <= BW'(BEATS - 1));
  // R10: done only after a completed final beat, with the engine idle
  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));
endmodule

// File: rtl/ctx_lane_map.sv
module ctx_lane_map
  import ctx_pkg::*;
#(
  parameter int WPB = 1,
  parameter int BW  = 5
) (
  input  logic [BW-1:0]        beat,
  output logic [WPB*SEL_W-1:0] sel,
  output logic [WPB-1:0]       vld
);
  for (genvar i = 0; i < WPB; i++) begin : g_lane
    always_comb begin
      int k;
      k = int'(beat) * WPB + i;
      vld[i] = (k < CTX_WORDS);
      if (k < GPR_COUNT)      sel[i*SEL_W +: SEL_W] = SEL_W'(GPR_COUNT - 1 - k);
      else if (k < CTX_WORDS) sel[i*SEL_W +: SEL_W] = SEL_STATUS;
      else                    sel[i*SEL_W +: SEL_W] = SEL_NONE;
    end
  end
endmodule

// File: rtl/ctx_switch_engine.sv
module ctx_switch_engine
  import ctx_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int THREADS = 8,
  localparam int WPB    = BUS_W / WORD_W,
  localparam int BEATS  = beats_for(BUS_W),
  localparam int BW     = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int AW     = (THREADS * BEATS > 1) ? $clog2(THREADS * BEATS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_restore,
  input  logic [TID_W-1:0]     cmd_tid,
  output logic                 cmd_reject,
  output logic                 busy,
  output logic                 done,
  output logic [WPB*SEL_W-1:0] rf_sel,
  output logic [WPB-1:0]       rf_lane_vld,
  input  logic [BUS_W-1:0]     rf_rdata,
  output logic [WPB-1:0]       rf_we,
  output logic [BUS_W-1:0]     rf_wdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [BUS_W-1:0]     mem_wdata,
  input  logic [BUS_W-1:0]     mem_rdata,
  input  logic                 mem_ready
);
  logic             op_restore;
  logic [TID_W-1:0] tid;
  logic [BW-1:0]    beat;
  logic [WPB-1:0]   lane_vld;

  ctx_beat_seq #(.BEATS(BEATS), .TID_W(TID_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_restore(cmd_restore),
    .cmd_tid    (cmd_tid),
    .mem_ready  (mem_ready),
    .cmd_reject (cmd_reject),
    .busy       (busy),
    .done       (done),
    .op_restore (op_restore),
    .tid        (tid),
    .beat       (beat)
  );

  ctx_lane_map #(.WPB(WPB), .BW(BW)) u_map (
    .beat(beat),
    .sel (rf_sel),
    .vld (lane_vld)
  );

  assign rf_lane_vld = busy ? lane_vld : '0;
  assign mem_req     = busy;
  assign mem_we      = busy && !op_restore;
  assign mem_addr    = AW'(tid) * AW'(BEATS) + AW'(beat);
  assign rf_wdata    = mem_rdata;

  for (genvar i = 0; i < WPB; i++) begin : g_dp
    assign rf_we[i] = busy && op_restore && mem_ready && lane_vld[i];
    assign mem_wdata[i*WORD_W +: WORD_W] =
      lane_vld[i] ? rf_rdata[i*WORD_W +: WORD_W] : '0;
  end

  // R9: register writes only during an accepted restore beat
  p_we_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rf_we) |-> (mem_req && !mem_we && mem_ready));
  // R6: address stays inside the context store
  p_addr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr < AW'(THREADS * BEATS)));
  // R7: a stalled beat keeps its address
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> $stable(mem_addr));
  // R1: quiet outputs while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && rf_we == '0));
endmodule

// File: tb/ctx_switch_engine_bench.sv
`timescale 1ns/1ps
module ctx_switch_engine_bench;
  localparam int BUS_W = 64;
  localparam int THR   = 4;
  localparam int WPB   = 2;
  localparam int BEATS = 9;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_restore, mem_ready;
  logic [1:0] cmd_tid;
  logic cmd_reject, busy, done, mem_req, mem_we;
  logic [WPB*5-1:0] rf_sel;
  logic [WPB-1:0] rf_lane_vld, rf_we;
  logic [BUS_W-1:0] rf_rdata, rf_wdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [31:0] salt;
  int vectors = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ctx_switch_engine #(.BUS_W(BUS_W), .THREADS(THR)) u_ctx_switch_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_restore(cmd_restore),
    .cmd_tid(cmd_tid), .cmd_reject(cmd_reject), .busy(busy), .done(done),
    .rf_sel(rf_sel), .rf_lane_vld(rf_lane_vld), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  function automatic logic [31:0] rf_val(input logic [4:0] s);
    return 32'hA000_0000 ^ (32'(s) * 32'h111) ^ salt;
  endfunction
  function automatic logic [31:0] mem_val(input logic [AW-1:0] a, input int lane);
    return 32'h5000_0000 ^ (32'(a) * 32'h10 + 32'(lane));
  endfunction

  always_comb begin
    for (int i = 0; i < WPB; i++) begin
      rf_rdata[i*32 +: 32]  = rf_val(rf_sel[i*5 +: 5]);
      mem_rdata[i*32 +: 32] = mem_val(mem_addr, i);
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Presumes the current time is a negedge with the engine ready for a
  // command; returns at the negedge of the done cycle.
  task automatic run_op(input bit rst, input int t, input bit stall, input int rej_beat);
    int b, cyc;
    bit rdy;
    cmd_valid = 1'b1; cmd_restore = rst; cmd_tid = 2'(t);
    #1 chk("R10 accept when idle", {63'd0, busy}, 64'd0);
    chk("R2 no reject when idle", {63'd0, cmd_reject}, 64'd0);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1 chk("R2 busy after accept", {63'd0, busy}, 64'd1);
    chk("R2 direction", {63'd0, mem_we}, {63'd0, !rst});
    b = 0; cyc = 0;
    while (b < BEATS) begin
      rdy = stall ? (((cyc + t) % 3) != 0) : 1'b1;
      mem_ready = rdy;
      if (b == rej_beat) begin
        cmd_valid = 1'b1; cmd_restore = !rst; cmd_tid = 2'(t ^ 1);
      end else cmd_valid = 1'b0;
      #1;
      chk("R3 reject flag", {63'd0, cmd_reject}, {63'd0, b == rej_beat});
      chk("R6 address", 64'(mem_addr), 64'(t * BEATS + b));
      chk("R2 mem_we held", {62'd0, mem_req, mem_we}, {62'd0, 1'b1, !rst});
      for (int i = 0; i < WPB; i++) begin
        int k;
        logic [4:0] es;
        bit v;
        k = b * WPB + i;
        v = (k < 17);
        es = (k < 16) ? 5'(15 - k) : (k < 17 ? 5'd16 : 5'd31);
        chk("R4 select", 64'(rf_sel[i*5 +: 5]), 64'(es));
        chk("R4 lane valid", 64'(rf_lane_vld[i]), 64'(v));
        if (!rst) begin
          chk("R8 save data", 64'(mem_wdata[i*32 +: 32]), v ? 64'(rf_val(es)) : 64'd0);
          chk("R7 no write on save", 64'(rf_we[i]), 64'd0);
        end else begin
          chk(rdy ? "R9 restore enable" : "R7 stall no write", 64'(rf_we[i]), 64'(rdy && v));
          chk("R9 restore data", 64'(rf_wdata[i*32 +: 32]), 64'(mem_val(mem_addr, i)));
        end
      end
      chk("R10 no early done", {63'd0, done}, 64'd0);
      @(negedge clk);
      cyc++;
      if (rdy) b++;
    end
    cmd_valid = 1'b0; mem_ready = 1'b0;
    #1 chk("R10 done pulse", {63'd0, done}, 64'd1);
    chk("R5 idle after BEATS", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_restore = 1'b0; cmd_tid = '0;
    mem_ready = 1'b0; salt = 32'h0;
    #3;
    chk("R1 reset busy", {63'd0, busy}, 64'd0);
    chk("R1 reset outputs", {60'd0, done, mem_req, rf_we}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {60'd0, busy, done, cmd_reject, mem_req}, 64'd0);
    for (int s = 0; s < 2; s++) begin
      for (int t = 0; t < THR; t++) begin
        for (int r = 0; r < 2; r++) begin
          salt = 32'(t * 7 + r * 3 + s * 11) << 8;
          run_op(r[0], t, s[0], (t + r + s) % 2 == 0 ? 3 + t : -1);
        end
      end
      @(negedge clk);
      chk("R10 single pulse", {63'd0, done}, 64'd0);
      repeat (2) @(negedge clk);
    end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule